// File: doc/BRIEF.md
# Sticky Interrupt Status Register

This block is the event-status and interrupt register of a data-link receiver card. Logic elsewhere on the card (receiver, receive FIFO, local memory controller) reports each fault or condition as a single-cycle pulse. The block records each pulse in a flag bit that stays set until software clears it by writing a zero to that bit. A global interrupt enable bit sits in the same register, and a per-flag mask in a second register picks which flags can raise the interrupt output.

An optional auto-disable mode clears the global enable as a side effect of reading the status register. An interrupt handler can then read the register once, which also turns off further interrupts. It handles the flags it found and writes the value it read back. That single write clears every flag that was zero in the read value, keeps every flag that was set, and restores the enable. Bus access is a plain 32-bit select/write/address port. Read data is combinational from the current register state.

Top module: `sticky_irq_status`

## Requirements
- R1: After reset all six flags, the global enable, the mask bits, the auto-disable bit and `irq` are 0, and both registers read as 0.
- R2: Each event pulse sets its flag in the status register (address 0) on the next clock, and the flag then stays set while no clearing write occurs. Bit positions are: bad data at bit 8, FIFO almost full at bit 9, FIFO full at bit 10, sync loss at bit 11, blocked narrow write at bit 12, parity error at bit 13.
- R3: A write to the status register clears each flag whose written bit is 0. A written 1 leaves that flag unchanged and never sets a clear flag.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: The global enable is bit 0 of the status register. Every status write loads it, and reads return it.
- R6: The control register (address 1) holds the auto-disable bit at bit 0. When that bit is 1, a read of the status register returns the enable as it stood and clears the enable on the next clock. Reads of the control register have no such effect.
- R7: When auto-disable is 0, reading the status register leaves the enable and the flags unchanged.
- R8: `irq` is 1 exactly when the enable is 1 and some set flag has its mask bit set. The mask bits sit at bits 8 to 13 of the control register, in the same positions as the flags.
- R9: Unused bits of both registers read as 0. Addresses 2 and 3 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 status, 1 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| ev_bad_data | input | 1 | Pulse: invalid received data |
| ev_fifo_afull | input | 1 | Pulse: receive FIFO almost full |
| ev_fifo_full | input | 1 | Pulse: receive FIFO full |
| ev_sync_loss | input | 1 | Pulse: receiver lost synchronization |
| ev_wr_blocked | input | 1 | Pulse: narrow write blocked in parity mode |
| ev_parity_err | input | 1 | Pulse: local memory parity error |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes zeros over a flag in the same cycle its event fires. A design where the clear wins would drop that flag. It also writes ones to flags that are already clear, which catches a write-one-to-set or write-one-to-clear mix-up. Auto-disable is checked both ways. With the mode on, a status read must still show the enable as 1 and then leave it at 0. A design that cleared the enable before returning the read data would show 0, and one that ignored the mode would leave `irq` high. Further checks cover mask gating, the difference between a status read and a control read, and the dead addresses.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int N_FLAGS  = 6;
  localparam int FLAG_LSB = 8;
  localparam int FLAG_MSB = FLAG_LSB + N_FLAGS - 1;
  localparam int GIE_BIT  = 0;
  localparam int ADC_BIT  = 0;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd1;

  // Next value of one sticky flag: a pulse sets it, a written 0 clears it,
  // and the pulse takes priority over the clear.
  function automatic logic flag_next(input logic cur, input logic ev,
                                     input logic we, input logic wbit);
    logic kill;
    kill = we & ~wbit;
    return ev | (cur & ~kill);
  endfunction

  // Interrupt request from enable, flags and mask.
  function automatic logic irq_of(input logic gie,
                                  input logic [N_FLAGS-1:0] flags,
                                  input logic [N_FLAGS-1:0] mask);
    return gie & (|(flags & mask));
  endfunction
endpackage

// File: rtl/sirq_flag_bank.sv
module sirq_flag_bank
  import sirq_pkg::*;
#(
  parameter int N = N_FLAGS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         wr_en,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flag_next(flags[i], ev[i], wr_en, wbits[i]);
    end
  end
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
#(
  parameter int N = N_FLAGS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_status,
  input  logic         rd_status,
  input  logic         wr_ctrl,
  input  logic         gie_wbit,
  input  logic         adc_wbit,
  input  logic [N-1:0] mask_wbits,
  output logic         gie,
  output logic         autoclr,
  output logic [N-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie <= 1'b0;
    end else if (wr_status) begin
      gie <= gie_wbit;
    end else if (rd_status && autoclr) begin
      gie <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      autoclr <= 1'b0;
      mask    <= '0;
    end else if (wr_ctrl) begin
      autoclr <= adc_wbit;
      mask    <= mask_wbits;
    end
  end
endmodule

// File: rtl/sticky_irq_status.sv
module sticky_irq_status
  import sirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_bad_data,
  input  logic              ev_fifo_afull,
  input  logic              ev_fifo_full,
  input  logic              ev_sync_loss,
  input  logic              ev_wr_blocked,
  input  logic              ev_parity_err,
  output logic              irq
);
  // Named internal events, brought out for the checker.
  logic               wr_status, rd_status, wr_ctrl, rd_ctrl;
  logic [N_FLAGS-1:0] ev_vec, flags, mask, clr_vec;
  logic               gie, autoclr;

  assign ev_vec = {ev_parity_err, ev_wr_blocked, ev_sync_loss,
                   ev_fifo_full, ev_fifo_afull, ev_bad_data};

  assign wr_status = bus_sel &  bus_wr & (bus_addr == ADDR_STATUS);
  assign rd_status = bus_sel & ~bus_wr & (bus_addr == ADDR_STATUS);
  assign wr_ctrl   = bus_sel &  bus_wr & (bus_addr == ADDR_CTRL);
  assign rd_ctrl   = bus_sel & ~bus_wr & (bus_addr == ADDR_CTRL);
  assign clr_vec   = wr_status ? ~bus_wdata[FLAG_MSB:FLAG_LSB] : '0;

  sirq_flag_bank #(.N(N_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev_vec),
    .wr_en (wr_status),
    .wbits (bus_wdata[FLAG_MSB:FLAG_LSB]),
    .flags (flags)
  );

  sirq_ctrl #(.N(N_FLAGS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_status  (wr_status),
    .rd_status  (rd_status),
    .wr_ctrl    (wr_ctrl),
    .gie_wbit   (bus_wdata[GIE_BIT]),
    .adc_wbit   (bus_wdata[ADC_BIT]),
    .mask_wbits (bus_wdata[FLAG_MSB:FLAG_LSB]),
    .gie        (gie),
    .autoclr    (autoclr),
    .mask       (mask)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_status) begin
      bus_rdata[FLAG_MSB:FLAG_LSB] = flags;
      bus_rdata[GIE_BIT]           = gie;
    end else if (rd_ctrl) begin
      bus_rdata[FLAG_MSB:FLAG_LSB] = mask;
      bus_rdata[ADC_BIT]           = autoclr;
    end
  end

  assign irq = irq_of(gie, flags, mask);
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker
  import sirq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [N_FLAGS-1:0] ev,
  input logic [N_FLAGS-1:0] flags,
  input logic [N_FLAGS-1:0] clr_vec,
  input logic               rd_status,
  input logic               wr_status,
  input logic               autoclr,
  input logic               gie,
  input logic               irq
);
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(flags) & ~$past(clr_vec)) & ~flags) == '0)); // R2
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((flags & $past(ev)) == $past(ev))); // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(ev)) == '0)); // R3
  AST_AUTO_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && autoclr) |=> !gie); // R6
  AST_READ_KEEPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !autoclr) |=> $stable(gie)); // R7
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0)); // R8
endmodule

bind sticky_irq_status sirq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev        (ev_vec),
  .flags     (flags),
  .clr_vec   (clr_vec),
  .rd_status (rd_status),
  .wr_status (wr_status),
  .autoclr   (autoclr),
  .gie       (gie),
  .irq       (irq)
);

// File: tb/sticky_irq_status_bench.sv
module sticky_irq_status_bench;
  localparam int VW = 43;
  localparam int NV = 29;
  localparam logic [1:0] IDLE = 2'd0, WR = 2'd1, RD = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  ev = '0;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sticky_irq_status u_sticky_irq_status (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_bad_data(ev[0]), .ev_fifo_afull(ev[1]), .ev_fifo_full(ev[2]),
    .ev_sync_loss(ev[3]), .ev_wr_blocked(ev[4]), .ev_parity_err(ev[5]),
    .irq(irq)
  );

  function automatic logic [VW-1:0] mk(input logic [1:0] op, input logic [1:0] a,
                                       input logic [15:0] wd, input logic [5:0] e,
                                       input logic [15:0] xr, input logic xi);
    return {op, a, wd, e, xr, xi};
  endfunction

  // op, addr, wdata, events, expected read data, expected irq after the step
  localparam logic [VW-1:0] VEC [NV] = '{
    mk(WR,   2'd1, 16'h3F00, 6'h00, 16'h0000, 1'b0), // 0 mask all, R8
    mk(IDLE, 2'd0, 16'h0000, 6'h01, 16'h0000, 1'b0), // 1 bad data, gie 0
    mk(IDLE, 2'd0, 16'h0000, 6'h00, 16'h0000, 1'b0), // 2 idle, R2 hold
    mk(RD,   2'd0, 16'h0000, 6'h00, 16'h0100, 1'b0), // 3 R2 bit 8
    mk(WR,   2'd0, 16'h3F01, 6'h00, 16'h0000, 1'b1), // 4 R5 enable
    mk(RD,   2'd0, 16'h0000, 6'h00, 16'h0101, 1'b1), // 5 R5 readback
    mk(WR,   2'd0, 16'h0001, 6'h00, 16'h0000, 1'b0), // 6 R3 clear
    mk(RD,   2'd0, 16'h0000, 6'h00, 16'h0001, 1'b0), // 7 R3
    mk(IDLE, 2'd0, 16'h0000, 6'h28, 16'h0000, 1'b1), // 8 parity+sync
    mk(RD,   2'd0, 16'h0000, 6'h00, 16'h2801, 1'b1), // 9 R2 bits 13,11
    mk(WR,   2'd0, 16'h0801, 6'h20, 16'h0000, 1'b1), // 10 R4 set wins
    mk(RD,   2'd0, 16'h0000, 6'h00, 16'h2801, 1'b1), // 11 R4
    mk(WR,   2'd1, 16'h0801, 6'h00, 16'h0000, 1'b1), // 12 mask sync, autoclr
    mk(RD,   2'd1, 16'h0000, 6'h00, 16'h0801, 1'b1), // 13 R6 ctrl read harmless
    mk(RD,   2'd0, 16'h0000, 6'h00, 16'h2801, 1'b0), // 14 R6 read then clear
    mk(RD,   2'd0, 16'h0000, 6'h00, 16'h2800, 1'b0), // 15 R6 gie now 0
    mk(WR,   2'd0, 16'h2801, 6'h00, 16'h0000, 1'b1), // 16 R6 write back
    mk(WR,   2'd1, 16'h0800, 6'h00, 16'h0000, 1'b1), // 17 autoclr off
    mk(RD,   2'd0, 16'h0000, 6'h00, 16'h2801, 1'b1), // 18 R7
    mk(RD,   2'd0, 16'h0000, 6'h00, 16'h2801, 1'b1), // 19 R7 still set
    mk(WR,   2'd0, 16'h0801, 6'h00, 16'h0000, 1'b1), // 20 clear parity
    mk(WR,   2'd1, 16'h2000, 6'h00, 16'h0000, 1'b0), // 21 R8 mask only parity
    mk(RD,   2'd2, 16'h0000, 6'h00, 16'h0000, 1'b0), // 22 R9 dead addr
    mk(WR,   2'd3, 16'hFFFF, 6'h00, 16'h0000, 1'b0), // 23 R9 dead write
    mk(RD,   2'd0, 16'h0000, 6'h00, 16'h0801, 1'b0), // 24 R9 state kept
    mk(WR,   2'd0, 16'h0000, 6'h00, 16'h0000, 1'b0), // 25 clear all
    mk(WR,   2'd0, 16'h3F00, 6'h00, 16'h0000, 1'b0), // 26 R3 ones do not set
    mk(RD,   2'd0, 16'h0000, 6'h00, 16'h0000, 1'b0), // 27 R3
    mk(WR,   2'd1, 16'hFFFF, 6'h00, 16'h0000, 1'b0)  // 28 all ctrl bits
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus step: drive at negedge, sample reads before the edge, release after.
  task automatic step(input logic [1:0] op, input logic [1:0] a, input logic [15:0] wd,
                      input logic [5:0] e, input logic [15:0] xr, input string req);
    bus_sel = (op != IDLE);
    bus_wr = (op == WR);
    bus_addr = a;
    bus_wdata = {16'h0000, wd};
    ev = e;
    #1;
    if (op == RD) check(req, bus_rdata, {16'h0000, xr});
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; ev = '0; bus_wdata = '0;
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    step(RD, 2'd0, 16'h0, 6'h0, 16'h0000, "R1 status");
    step(RD, 2'd1, 16'h0, 6'h0, 16'h0000, "R1 control");

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[42:41], v[40:39], v[38:23], v[22:17], v[16:1], $sformatf("R2-step%0d rdata", i));
      check($sformatf("R8 step%0d irq", i), {31'd0, irq}, {31'd0, v[0]});
    end

    // R9: unused control bits read 0
    step(RD, 2'd1, 16'h0, 6'h0, 16'h3F01, "R9 ctrl unused bits");

    // R2: each event alone lands at its bit
    step(WR, 2'd0, 16'h0000, 6'h00, 16'h0, "");
    for (int b = 0; b < 6; b++) begin
      step(IDLE, 2'd0, 16'h0, 6'(1 << b), 16'h0, "");
      step(RD, 2'd0, 16'h0, 6'h0, 16'(1 << (b + 8)), $sformatf("R2 event %0d", b));
      step(WR, 2'd0, 16'h0000, 6'h00, 16'h0, "");
    end

    // R6: auto-disable with irq pending
    step(IDLE, 2'd0, 16'h0, 6'h04, 16'h0, "");
    step(WR, 2'd0, 16'h3F01, 6'h0, 16'h0, "");
    check("R8 irq on", {31'd0, irq}, 32'd1);
    step(RD, 2'd0, 16'h0, 6'h0, 16'h0401, "R6 returns old gie");
    check("R6 irq off", {31'd0, irq}, 32'd0);

    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    #3;
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step(RD, 2'd0, 16'h0, 6'h0, 16'h0000, "R1 status after reset");
    step(RD, 2'd1, 16'h0, 6'h0, 16'h0000, "R1 control after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule